// File: doc/BRIEF.md
# AC-link Frame Controller

This block is the controller end of a five-wire serial audio link to a codec. The codec supplies the bit clock. The controller produces the frame marker and drives an active-low reset line to the codec. In each sample period it sends one 256-bit frame on the playback line and collects one 256-bit frame from the capture line. Each frame is split into a 16-bit tag slot followed by twelve 20-bit data slots.

On the user side there is a flat vector of outgoing slot words with one valid flag per slot. There is also a flat vector of captured slot words, the captured tag, and a one-cycle strobe that marks a completed frame. Everything runs on the system clock `clk`. The codec bit clock and capture data are brought in through two-stage synchronisers, and each bit-clock edge is detected as a one-cycle event.

The sequencer has three states:
- `ST_HOLD_RESET` holds the codec in reset for `RESET_CYCLES` system clocks. The transition T_RELEASE moves it to `ST_WAIT_CLOCK`.
- `ST_WAIT_CLOCK` counts `WARM_EDGES` rising bit-clock edges. The transition T_LOCK moves it to `ST_RUN`.
- `ST_RUN` frames continuously. Only the system reset `rst_n` leaves it, and it returns to `ST_HOLD_RESET`.

Top module: `aclink_ctrl`

## Requirements
- R1: While `rst_n` is low, and for `RESET_CYCLES` (64) system clocks after it rises, `ac_reset_n` is low. It then goes high and stays high while `rst_n` stays high. `ac_sync`, `ac_sdout` and `frame_done` are low during this whole time.
- R2: No frame marker appears before `WARM_EDGES` (4) rising bit-clock edges have been seen after `ac_reset_n` rises. With the bit clock stopped, `ac_sync` stays low. The first frame begins on rising edge number `WARM_EDGES`+1.
- R3: A frame is 256 bit clocks long. `ac_sync` is high for the 16 tag bit positions and low for the other 240. Frames follow one another with no gap.
- R4: `ac_sync` and `ac_sdout` change only in response to a rising bit-clock edge and hold until the next one.
- R5: The tag slot is sent MSB first. Bit 15 is the frame-valid flag, equal to the OR of all `tx_valid` bits. Bits 14 down to 3 carry `tx_valid[0]` down to `tx_valid[11]`. Bits 2..0 are zero.
- R6: Data slots 1 to 12 follow the tag in that order, 20 bits each, MSB first. Slot n is `tx_data[(n-1)*20 +: 20]`. A slot whose `tx_valid[n-1]` is low is sent as all zeros.
- R7: `tx_data` and `tx_valid` are captured on the rising edge that sends the first tag bit. A change in the middle of a frame takes effect only in the next frame.
- R8: `ac_sdin` is sampled on falling bit-clock edges. The first 16 bits of a frame land in `rx_tag[15:0]`, MSB first. Slot n lands in `rx_data[(n-1)*20 +: 20]`, MSB first.
- R9: `frame_done` pulses for exactly one system clock after the last bit of each frame has been sampled. `rx_tag` and `rx_data` change only together with that pulse.
- R10: When `rst_n` is asserted in the middle of a frame, `ac_reset_n`, `ac_sync`, `ac_sdout`, `frame_done` and `rx_tag` drop to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ac_bclk | input | 1 | Bit clock from the codec |
| ac_sdin | input | 1 | Serial capture data from the codec |
| ac_reset_n | output | 1 | Active-low reset to the codec |
| ac_sync | output | 1 | Frame marker, high during the tag slot |
| ac_sdout | output | 1 | Serial playback data to the codec |
| tx_data | input | NUM_SLOTS*SLOT_W | Outgoing slot words, slot 1 in the lowest bits |
| tx_valid | input | NUM_SLOTS | Valid flag per outgoing slot |
| rx_tag | output | TAG_W | Tag slot of the last captured frame |
| rx_data | output | NUM_SLOTS*SLOT_W | Captured slot words, slot 1 in the lowest bits |
| frame_done | output | 1 | One-cycle strobe at the end of each frame |

## Verification
The bench plays the codec. It counts rising edges from the moment the codec reset is released, so a design that started framing too early or too late would show the first marker on the wrong edge. Outgoing frames are scored against a queue of expected frames, and the slot inputs are changed halfway through each frame. A design that captured its inputs continuously, rather than at frame start, would send a frame mixing old and new words. The valid patterns include none valid, only the last slot valid and alternating slots, with non-zero words in the invalid slots. These catch a tag bit that is shifted off by one, and catch invalid slots that are not cleared to zero. Captured frames with distinct bit patterns catch reversed bit order, slots landing in the wrong place and off-by-one sampling. A mid-frame reset catches outputs that only clear on a clock edge.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

    typedef enum logic [1:0] {
        ST_HOLD_RESET = 2'd0,
        ST_WAIT_CLOCK = 2'd1,
        ST_RUN        = 2'd2
    } link_state_e;

endpackage

// File: rtl/aclink_pin_sync.sv
// Brings the codec bit clock and capture data into the clk domain and
// turns bit-clock transitions into one-cycle rise/fall events.
module aclink_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_pin,
    input  logic sdin_pin,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic sdin_s
);

    logic [1:0] bclk_pipe_q;
    logic       bclk_prev_q;
    logic [1:0] sdin_pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_pipe_q <= '0;
            bclk_prev_q <= 1'b0;
            sdin_pipe_q <= '0;
        end else begin
            bclk_pipe_q <= {bclk_pipe_q[0], bclk_pin};
            bclk_prev_q <= bclk_pipe_q[1];
            sdin_pipe_q <= {sdin_pipe_q[0], sdin_pin};
        end
    end

    assign bclk_rise = bclk_pipe_q[1] & ~bclk_prev_q;
    assign bclk_fall = ~bclk_pipe_q[1] & bclk_prev_q;
    assign sdin_s    = sdin_pipe_q[1];

endmodule

// File: rtl/aclink_tx_framer.sv
// Builds the outgoing frame (tag plus masked slots) at frame start and
// shifts it out MSB first, one bit per rising bit-clock event.
module aclink_tx_framer #(
    parameter int NUM_SLOTS = 12,
    parameter int SLOT_W    = 20,
    parameter int TAG_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift,
    input  logic                        load,
    input  logic                        sync_val,
    input  logic [NUM_SLOTS*SLOT_W-1:0] tx_data,
    input  logic [NUM_SLOTS-1:0]        tx_valid,
    output logic                        sdout,
    output logic                        sync
);

    localparam int PAY_W      = NUM_SLOTS * SLOT_W;
    localparam int FRAME_BITS = TAG_W + PAY_W;

    logic [TAG_W-1:0]      tag_word;
    logic [PAY_W-1:0]      payload;
    logic [FRAME_BITS-1:0] frame_vec;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  sdout_q;
    logic                  sync_q;

    always_comb begin
        tag_word = '0;
        tag_word[TAG_W-1] = |tx_valid;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            tag_word[TAG_W-2-k] = tx_valid[k];
        end
    end

    // Slot 1 goes first on the wire, so it sits at the top of the payload.
    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            assign payload[PAY_W-1-s*SLOT_W -: SLOT_W] =
                tx_valid[s] ? tx_data[s*SLOT_W +: SLOT_W] : '0;
        end
    endgenerate

    assign frame_vec = {tag_word, payload};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            sdout_q <= 1'b0;
            sync_q  <= 1'b0;
        end else if (shift) begin
            sync_q <= sync_val;
            if (load) begin
                sdout_q <= frame_vec[FRAME_BITS-1];
                shreg_q <= {frame_vec[FRAME_BITS-2:0], 1'b0};
            end else begin
                sdout_q <= shreg_q[FRAME_BITS-1];
                shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    assign sdout = sdout_q;
    assign sync  = sync_q;

endmodule

// File: rtl/aclink_rx_deframer.sv
// Shifts capture bits in on falling bit-clock events and unpacks the
// whole frame into tag and slot registers after its last bit.
module aclink_rx_deframer #(
    parameter int NUM_SLOTS = 12,
    parameter int SLOT_W    = 20,
    parameter int TAG_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample,
    input  logic                        last_bit,
    input  logic                        sdin,
    output logic [TAG_W-1:0]            rx_tag,
    output logic [NUM_SLOTS*SLOT_W-1:0] rx_data,
    output logic                        frame_done
);

    localparam int PAY_W      = NUM_SLOTS * SLOT_W;
    localparam int FRAME_BITS = TAG_W + PAY_W;

    logic [FRAME_BITS-1:0] shreg_q;
    logic [FRAME_BITS-1:0] frame_in;
    logic [PAY_W-1:0]      unpacked;
    logic [TAG_W-1:0]      tag_q;
    logic [PAY_W-1:0]      data_q;
    logic                  done_q;

    assign frame_in = {shreg_q[FRAME_BITS-2:0], sdin};

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_unpack
            assign unpacked[s*SLOT_W +: SLOT_W] = frame_in[PAY_W-1-s*SLOT_W -: SLOT_W];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            tag_q   <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (sample) begin
                shreg_q <= frame_in;
                if (last_bit) begin
                    tag_q  <= frame_in[FRAME_BITS-1 -: TAG_W];
                    data_q <= unpacked;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign rx_tag     = tag_q;
    assign rx_data    = data_q;
    assign frame_done = done_q;

endmodule

// File: rtl/aclink_ctrl.sv
module aclink_ctrl
    import aclink_pkg::*;
#(
    parameter int NUM_SLOTS    = 12,
    parameter int SLOT_W       = 20,
    parameter int TAG_W        = 16,
    parameter int RESET_CYCLES = 64,
    parameter int WARM_EDGES   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ac_bclk,
    input  logic                        ac_sdin,
    output logic                        ac_reset_n,
    output logic                        ac_sync,
    output logic                        ac_sdout,
    input  logic [NUM_SLOTS*SLOT_W-1:0] tx_data,
    input  logic [NUM_SLOTS-1:0]        tx_valid,
    output logic [TAG_W-1:0]            rx_tag,
    output logic [NUM_SLOTS*SLOT_W-1:0] rx_data,
    output logic                        frame_done
);

    localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int RST_W      = $clog2(RESET_CYCLES + 1);
    localparam int WARM_W     = $clog2(WARM_EDGES + 1);

    link_state_e       state_q, state_d;
    logic [RST_W-1:0]  rst_cnt_q;
    logic [WARM_W-1:0] warm_cnt_q;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  drive_pos_q;
    logic              started_q;
    logic              link_running;
    logic              bclk_rise, bclk_fall, sdin_s;
    logic              tx_step, frame_start, rx_step, rx_last;

    aclink_pin_sync i_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_pin  (ac_bclk),
        .sdin_pin  (ac_sdin),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .sdin_s    (sdin_s)
    );

    // Next-state logic: T_RELEASE and T_LOCK.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD_RESET: if (rst_cnt_q == RST_W'(RESET_CYCLES - 1)) state_d = ST_WAIT_CLOCK;
            ST_WAIT_CLOCK: if (bclk_rise && warm_cnt_q == WARM_W'(WARM_EDGES - 1)) state_d = ST_RUN;
            ST_RUN:        state_d = ST_RUN;
            default:       state_d = ST_HOLD_RESET;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // State outputs.
    always_comb begin
        ac_reset_n   = 1'b0;
        link_running = 1'b0;
        unique case (state_q)
            ST_HOLD_RESET: ;
            ST_WAIT_CLOCK: ac_reset_n = 1'b1;
            ST_RUN: begin
                ac_reset_n   = 1'b1;
                link_running = 1'b1;
            end
            default: ;
        endcase
    end

    // Sequencing counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_cnt_q  <= '0;
            warm_cnt_q <= '0;
        end else begin
            if (state_q == ST_HOLD_RESET) rst_cnt_q <= rst_cnt_q + 1'b1;
            if (state_q == ST_WAIT_CLOCK && bclk_rise) warm_cnt_q <= warm_cnt_q + 1'b1;
        end
    end

    assign tx_step     = link_running & bclk_rise;
    assign frame_start = tx_step & (pos_q == '0);

    // Slot/bit position: pos_q is the next bit to send, drive_pos_q the
    // bit currently on the wire (the one the codec answers on the fall).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q       <= '0;
            drive_pos_q <= '0;
            started_q   <= 1'b0;
        end else if (tx_step) begin
            drive_pos_q <= pos_q;
            started_q   <= 1'b1;
            pos_q       <= (pos_q == POS_W'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
        end
    end

    assign rx_step = link_running & bclk_fall & started_q;
    assign rx_last = (drive_pos_q == POS_W'(FRAME_BITS - 1));

    aclink_tx_framer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .TAG_W     (TAG_W)
    ) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (tx_step),
        .load     (frame_start),
        .sync_val (pos_q < POS_W'(TAG_W)),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .sdout    (ac_sdout),
        .sync     (ac_sync)
    );

    aclink_rx_deframer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .TAG_W     (TAG_W)
    ) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (rx_step),
        .last_bit   (rx_last),
        .sdin       (sdin_s),
        .rx_tag     (rx_tag),
        .rx_data    (rx_data),
        .frame_done (frame_done)
    );

endmodule

// File: rtl/aclink_checker.sv
module aclink_checker #(
    parameter int TAG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ac_reset_n,
    input logic             ac_sync,
    input logic             ac_sdout,
    input logic             frame_done,
    input logic [TAG_W-1:0] rx_tag,
    input logic             bclk_rise
);

    assert_codec_reset_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ac_reset_n));

    assert_no_sync_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ac_reset_n |-> !ac_sync);

    assert_sync_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ac_sync) |-> $past(bclk_rise));

    assert_sdout_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ac_sdout) |-> $past(bclk_rise));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_tag_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_tag) |-> frame_done);

    assert_done_outside_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !ac_sync);

endmodule

bind aclink_ctrl aclink_checker #(.TAG_W(TAG_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ac_reset_n (ac_reset_n),
    .ac_sync    (ac_sync),
    .ac_sdout   (ac_sdout),
    .frame_done (frame_done),
    .rx_tag     (rx_tag),
    .bclk_rise  (bclk_rise)
);

// File: tb/test_aclink_ctrl.sv
module test_aclink_ctrl;

    localparam int NS   = 12;
    localparam int SW   = 20;
    localparam int TW   = 16;
    localparam int RC   = 64;
    localparam int WE   = 4;
    localparam int PW   = NS * SW;
    localparam int FB   = TW + PW;
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bclk = 1'b0;
    logic          sdin = 1'b0;
    logic [PW-1:0] tx_data = '0;
    logic [NS-1:0] tx_valid = '0;
    logic          ac_reset_n, ac_sync, ac_sdout, frame_done;
    logic [TW-1:0] rx_tag;
    logic [PW-1:0] rx_data;

    aclink_ctrl #(
        .NUM_SLOTS(NS), .SLOT_W(SW), .TAG_W(TW), .RESET_CYCLES(RC), .WARM_EDGES(WE)
    ) i_aclink_ctrl (
        .clk(clk), .rst_n(rst_n), .ac_bclk(bclk), .ac_sdin(sdin),
        .ac_reset_n(ac_reset_n), .ac_sync(ac_sync), .ac_sdout(ac_sdout),
        .tx_data(tx_data), .tx_valid(tx_valid),
        .rx_tag(rx_tag), .rx_data(rx_data), .frame_done(frame_done)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [FB-1:0] txq[$];
    logic [FB-1:0] rxq[$];
    bit  bclk_run = 1'b0;
    bit  mon_on = 1'b0;
    int  rises = 0;
    int  frames = 0;
    int  pos = -1;
    int  first_rise = -1;
    int  done_cnt = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [FB-1:0] act, input logic [FB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic logic [FB-1:0] exp_tx(input logic [PW-1:0] d, input logic [NS-1:0] v);
        logic [FB-1:0] f;
        f = '0;
        f[FB-1] = |v;
        for (int k = 0; k < NS; k++) f[FB-2-k] = v[k];
        for (int s = 0; s < NS; s++)
            if (v[s]) f[PW-1-s*SW -: SW] = d[s*SW +: SW];
        return f;
    endfunction

    function automatic logic [FB-1:0] rx_pat(input int f);
        logic [FB-1:0] r;
        r = '0;
        for (int i = 0; i < FB/32; i++)
            r[i*32 +: 32] = (32'h9E3779B9 * (f*8 + i + 1)) ^ 32'h5BD1E995;
        return r;
    endfunction

    task automatic drive_tx(input int j);
        logic [PW-1:0] d;
        logic [NS-1:0] v;
        case (j)
            0: v = 12'hFFF;
            1: v = 12'h000;
            2: v = 12'h555;
            3: v = 12'h800;
            4: v = 12'h001;
            default: v = 12'hA6B;
        endcase
        for (int s = 0; s < NS; s++)
            d[s*SW +: SW] = SW'(32'h3A5C7 * (j + 1) + 32'h1F3 * (s + 1));
        if (j == 3) d[(NS-1)*SW +: SW] = '1;
        if (j == 4) d[0 +: SW] = 20'h80001;
        tx_data  = d;
        tx_valid = v;
        txq.push_back(exp_tx(d, v));
    endtask

    // Codec model: drives the bit clock and capture data, watches the outputs.
    initial begin
        logic          prev_s;
        logic          s_now, o_now;
        logic [FB-1:0] out_frame;
        logic [FB-1:0] cur_rx;
        logic [FB-1:0] exp;
        int            hi_cnt;
        prev_s = 1'b0;
        out_frame = '0;
        cur_rx = '0;
        hi_cnt = 0;
        forever begin
            @(negedge clk);
            if (bclk_run) begin
                bclk = 1'b1;
                rises++;
                repeat (4) @(negedge clk);
                s_now = ac_sync;
                o_now = ac_sdout;
                if (s_now && !prev_s) begin
                    if (pos >= 0 && mon_on)
                        check(pos == FB-1, "R3", "frame length", FB'(pos + 1), FB'(FB));
                    pos = 0;
                    frames++;
                    if (first_rise < 0) first_rise = rises;
                    cur_rx = rx_pat(frames);
                    rxq.push_back(cur_rx);
                    hi_cnt = 0;
                end else if (pos >= 0) begin
                    pos++;
                end
                prev_s = s_now;
                if (pos >= 0 && pos < FB) begin
                    out_frame[FB-1-pos] = o_now;
                    if (s_now) hi_cnt++;
                    sdin = cur_rx[FB-1-pos];
                    if (pos == FB-1 && mon_on) begin
                        check(hi_cnt == TW, "R3", "sync high bits", FB'(hi_cnt), FB'(TW));
                        if (txq.size() > 0) begin
                            exp = txq.pop_front();
                            check(out_frame[FB-1 -: TW] == exp[FB-1 -: TW], "R5", "tag slot",
                                  FB'(out_frame[FB-1 -: TW]), FB'(exp[FB-1 -: TW]));
                            check(out_frame[PW-1:0] == exp[PW-1:0], "R6/R7", "data slots",
                                  FB'(out_frame[PW-1:0]), FB'(exp[PW-1:0]));
                        end
                    end
                end
                repeat (2) @(negedge clk);
                bclk = 1'b0;
                repeat (4) @(negedge clk);
                if (mon_on)
                    check(ac_sync == s_now && ac_sdout == o_now, "R4", "outputs held to next rise",
                          FB'({ac_sync, ac_sdout}), FB'({s_now, o_now}));
            end
        end
    end

    // Capture-side monitor.
    initial begin
        logic          prev_done;
        logic [FB-1:0] e;
        logic [PW-1:0] ed;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && mon_on) begin
                if (prev_done)
                    check(!frame_done, "R9", "done pulse width", FB'(frame_done), '0);
                if (frame_done) begin
                    done_cnt++;
                    if (rxq.size() > 0) begin
                        e = rxq.pop_front();
                        for (int s = 0; s < NS; s++) ed[s*SW +: SW] = e[PW-1-s*SW -: SW];
                        check(rx_tag == e[FB-1 -: TW], "R8", "captured tag",
                              FB'(rx_tag), FB'(e[FB-1 -: TW]));
                        check(rx_data == ed, "R8", "captured slots", FB'(rx_data), FB'(ed));
                    end
                end
            end
            prev_done = frame_done;
        end
    end

    // Driver: new slot inputs in the middle of each frame.
    initial begin
        for (int j = 1; j <= 5; j++) begin
            while (!(frames == j && pos >= 128)) @(negedge clk);
            drive_tx(j);
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bit bad;
        drive_tx(0);
        repeat (5) @(negedge clk);
        check(ac_reset_n == 1'b0 && ac_sync == 1'b0 && ac_sdout == 1'b0 && frame_done == 1'b0,
              "R1", "outputs in reset", FB'({ac_reset_n, ac_sync, ac_sdout, frame_done}), '0);
        rst_n = 1'b1;
        repeat (RC - 4) @(negedge clk);
        check(ac_reset_n == 1'b0, "R1", "codec reset held", FB'(ac_reset_n), '0);
        repeat (8) @(negedge clk);
        check(ac_reset_n == 1'b1, "R1", "codec reset released", FB'(ac_reset_n), FB'(1));
        bad = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (ac_sync || ac_sdout || frame_done || !ac_reset_n) bad = 1'b1;
        end
        check(!bad, "R2", "quiet with bit clock stopped", FB'(bad), '0);
        mon_on = 1'b1;
        bclk_run = 1'b1;
        while (frames < 8) @(negedge clk);
        check(first_rise == WE + 1, "R2", "first frame rise", FB'(first_rise), FB'(WE + 1));
        check(done_cnt == frames - 1, "R9", "one done per frame", FB'(done_cnt), FB'(frames - 1));
        while (pos != 100) @(negedge clk);
        mon_on = 1'b0;
        bclk_run = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(ac_reset_n == 1'b0 && ac_sync == 1'b0 && ac_sdout == 1'b0 && frame_done == 1'b0,
              "R10", "async reset mid-frame", FB'({ac_reset_n, ac_sync, ac_sdout, frame_done}), '0);
        check(rx_tag == '0, "R10", "captured tag cleared", FB'(rx_tag), '0);
        repeat (20) @(negedge clk);
        summary();
        $finish;
    end

endmodule